// File: doc/BRIEF.md
# Ethernet Inter-Packet Gap Timer

This block decides when the transmit side of a 10/100 Mb/s MAC may start a frame. It holds off the transmitter for a programmable spacing after each frame it sends itself. In half duplex it also defers to traffic from other stations: once carrier from the line goes away, it runs a two-phase wait before it lets the transmitter start. Three 7-bit spacing values are taken from fields of a shared configuration word. These are the spacing after the block's own frame, the first deferral phase and the second deferral phase. A typical setting is 21, 17 and 11 increments.

The spacing is counted in increments. A free-running `tick` input marks the base time unit (80 ns). In 100 Mb/s mode one increment is one tick. In 10 Mb/s mode one increment is `SLOW_DIV` ticks, which makes it 800 ns. Each spacing value is captured at the moment its phase begins, so changing the configuration word never stretches or shortens a phase already in progress.

The MAC raises `tx_req` while `tx_permit` is high to claim the medium. It pulses `tx_done` when its frame has left. Collision backoff, serialisation and the PHY interface are handled elsewhere.

Top module: `ipg_timer`

## Requirements
- R1: After reset, with carrier low, `tx_permit` is 1.
- R2: A cycle with `tx_req` and `tx_permit` both high starts an own transmission. `tx_permit` is then 0 until `tx_done` has been seen and the following gap has elapsed.
- R3: After `tx_done`, `tx_permit` stays 0 for N increments, where N is `cfg_word[14:8]`. It rises within two clock cycles of the N-th increment.
- R4: An increment is 1 tick when `speed_100`=1 and `SLOW_DIV` (default 10) ticks when `speed_100`=0. The tick count restarts at the start of every gap phase.
- R5: In half duplex (`full_duplex`=0), carrier high forces `tx_permit` to 0. After carrier falls, `tx_permit` rises only after A+B increments, where A is `cfg_word[21:15]` and B is `cfg_word[28:22]`.
- R6: Carrier seen during the first deferral phase (A) restarts the deferral. A full A+B wait is then required after carrier falls again.
- R7: Carrier seen during the second deferral phase (B) has no effect on when that phase ends.
- R8: In full duplex (`full_duplex`=1), carrier is ignored. `tx_permit` is 1 while idle, and only the gap of R3 applies after an own frame.
- R9: Each spacing value is sampled when its phase begins. Changing `cfg_word` during a phase does not alter that phase; the new value applies from the next phase.
- R10: A spacing value of 0 gives a zero-length phase. With N=0, `tx_permit` returns within two cycles of `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per base time unit (80 ns) |
| cfg_word | input | CFG_W (32) | Configuration word; spacing fields at bits 14:8, 21:15, 28:22 |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | 1 = full duplex, carrier ignored |
| crs | input | 1 | Carrier sense from the line |
| tx_done | input | 1 | One-cycle pulse at the end of an own frame |
| tx_req | input | 1 | Claim the medium when permitted |
| tx_permit | output | 1 | High when a frame may start |

## Verification
The bench builds the block with its default parameters: 7-bit spacing fields, the standard field positions and a slow-mode divider of 10. Because the divider is small, even the largest typical spacing (21 increments at 10 Mb/s, 210 ticks) can be stepped one tick at a time, and the output is compared with the arithmetic expectation after every tick. Both speeds are swept over a set of spacing values that includes zero, one and the typical settings. Carrier is injected inside each deferral phase and at phase edges, in both duplex modes. The configuration word is also rewritten while a gap is running.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

    typedef enum logic [2:0] {
        ST_READY   = 3'd0,
        ST_BUSY    = 3'd1,
        ST_B2B     = 3'd2,
        ST_CARRIER = 3'd3,
        ST_DEFER1  = 3'd4,
        ST_DEFER2  = 3'd5
    } ipg_state_e;

endpackage

// File: rtl/ipg_unit_strobe.sv
module ipg_unit_strobe #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fast,
    input  logic clear,
    output logic unit
);

    generate
        if (DIV <= 1) begin : g_direct
            logic unused_fast;
            assign unused_fast = fast;
            assign unit = tick && !clear;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);

            typedef struct packed {
                logic [PW-1:0] pre;
            } pre_t;

            pre_t p_d, p_q;
            logic wrap;

            assign wrap = (p_q.pre == LAST);

            always_comb begin
                p_d = p_q;
                if (clear) begin
                    p_d.pre = '0;
                end else if (tick && !fast) begin
                    p_d.pre = wrap ? '0 : p_q.pre + PW'(1);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    p_q <= '0;
                end else begin
                    p_q <= p_d;
                end
            end

            assign unit = !clear && tick && (fast || wrap);
        end
    endgenerate

endmodule

// File: rtl/ipg_gap_counter.sv
module ipg_gap_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         unit,
    output logic         expired,
    output logic [W-1:0] count
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.cnt = load_val;
        end else if (unit && (c_q.cnt != '0)) begin
            c_d.cnt = c_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign expired = (c_q.cnt == '0);
    assign count   = c_q.cnt;

endmodule

// File: rtl/ipg_timer.sv
module ipg_timer
    import ipg_pkg::*;
#(
    parameter int CFG_W     = 32,
    parameter int GAP_W     = 7,
    parameter int B2B_LSB   = 8,
    parameter int DEF1_LSB  = 15,
    parameter int DEF2_LSB  = 22,
    parameter int SLOW_DIV  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             speed_100,
    input  logic             full_duplex,
    input  logic             crs,
    input  logic             tx_done,
    input  logic             tx_req,
    output logic             tx_permit
);

    typedef struct packed {
        ipg_state_e st;
    } fsm_t;

    fsm_t             s_d, s_q;
    logic [GAP_W-1:0] b2b_val, def1_val, def2_val;
    logic [GAP_W-1:0] load_val, gap_cnt;
    logic             load, unit, expired, half;
    ipg_state_e       cur_st;
    logic             unused_cfg;

    assign b2b_val    = cfg_word[B2B_LSB  +: GAP_W];
    assign def1_val   = cfg_word[DEF1_LSB +: GAP_W];
    assign def2_val   = cfg_word[DEF2_LSB +: GAP_W];
    assign unused_cfg = ^cfg_word;
    assign half       = !full_duplex;
    assign cur_st     = s_q.st;

    ipg_unit_strobe #(.DIV(SLOW_DIV)) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .fast  (speed_100),
        .clear (load),
        .unit  (unit)
    );

    ipg_gap_counter #(.W(GAP_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .unit     (unit),
        .expired  (expired),
        .count    (gap_cnt)
    );

    assign tx_permit = (s_q.st == ST_READY) && !(half && crs);

    always_comb begin
        s_d      = s_q;
        load     = 1'b0;
        load_val = '0;
        unique case (s_q.st)
            ST_READY: begin
                if (tx_req && tx_permit) begin
                    s_d.st = ST_BUSY;
                end else if (half && crs) begin
                    s_d.st = ST_CARRIER;
                end
            end
            ST_BUSY: begin
                if (tx_done) begin
                    s_d.st   = ST_B2B;
                    load     = 1'b1;
                    load_val = b2b_val;
                end
            end
            ST_B2B: begin
                if (expired) begin
                    s_d.st = ST_READY;
                end
            end
            ST_CARRIER: begin
                if (!half) begin
                    s_d.st = ST_READY;
                end else if (!crs) begin
                    s_d.st   = ST_DEFER1;
                    load     = 1'b1;
                    load_val = def1_val;
                end
            end
            ST_DEFER1: begin
                if (half && crs) begin
                    s_d.st = ST_CARRIER;
                end else if (expired) begin
                    s_d.st   = ST_DEFER2;
                    load     = 1'b1;
                    load_val = def2_val;
                end
            end
            ST_DEFER2: begin
                if (expired) begin
                    s_d.st = ST_READY;
                end
            end
            default: s_d.st = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st <= ST_READY;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ipg_timer_chk.sv
module ipg_timer_chk
    import ipg_pkg::*;
#(
    parameter int GAP_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_req,
    input logic             tx_done,
    input logic             crs,
    input logic             full_duplex,
    input logic             tx_permit,
    input ipg_state_e       st,
    input logic             load,
    input logic [GAP_W-1:0] gap_cnt
);

    a_r2_claim_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_permit) |=> !tx_permit);

    a_r3_done_opens_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && tx_done) |=> !tx_permit);

    a_r5_carrier_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && crs) |-> !tx_permit);

    a_r6_carrier_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEFER1 && crs && !full_duplex) |=> (st == ST_CARRIER));

    a_r7_phase2_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEFER2) |=> (st == ST_DEFER2 || st == ST_READY));

    a_r8_fdx_idle_open: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex && st == ST_READY) |-> tx_permit);

    a_r9_count_only_loads: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (gap_cnt <= $past(gap_cnt)));

endmodule

bind ipg_timer ipg_timer_chk #(.GAP_W(GAP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_req      (tx_req),
    .tx_done     (tx_done),
    .crs         (crs),
    .full_duplex (full_duplex),
    .tx_permit   (tx_permit),
    .st          (cur_st),
    .load        (load),
    .gap_cnt     (gap_cnt)
);

// File: tb/tb_ipg_timer.sv
module tb_ipg_timer;

    localparam int DIV = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        speed_100 = 1'b1;
    logic        full_duplex = 1'b0;
    logic        crs = 1'b0;
    logic        tx_done = 1'b0;
    logic        tx_req = 1'b0;
    logic        tx_permit;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ipg_timer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cfg_word    (cfg_word),
        .speed_100   (speed_100),
        .full_duplex (full_duplex),
        .crs         (crs),
        .tx_done     (tx_done),
        .tx_req      (tx_req),
        .tx_permit   (tx_permit)
    );

    function automatic logic [31:0] mk_cfg(input int b2b, input int d1, input int d2);
        return (32'(d2) << 22) | (32'(d1) << 15) | (32'(b2b) << 8);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: tx_permit=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        cyc(1);
        tick = 1'b0;
        cyc(2);
    endtask

    task automatic run_gap(input int need, input string tag);
        cyc(4);
        chk(tx_permit, need == 0, tag);
        for (int i = 1; i <= need; i++) begin
            pulse_tick();
            chk(tx_permit, i >= need, tag);
        end
    endtask

    task automatic send_frame(input int need, input string tag);
        tx_req = 1'b1;
        cyc(1);
        tx_req = 1'b0;
        chk(tx_permit, 1'b0, "R2 claim");
        pulse_tick();
        pulse_tick();
        chk(tx_permit, 1'b0, "R2 busy");
        tx_done = 1'b1;
        cyc(1);
        tx_done = 1'b0;
        run_gap(need, tag);
    endtask

    task automatic carrier_event(input int need, input string tag);
        crs = 1'b1;
        cyc(2);
        chk(tx_permit, 1'b0, "R5 carrier high");
        pulse_tick();
        pulse_tick();
        chk(tx_permit, 1'b0, "R5 carrier held");
        crs = 1'b0;
        run_gap(need, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int k;
        int b2b_set[6] = '{0, 1, 2, 3, 7, 21};
        int d1_set[5]  = '{0, 1, 0, 2, 17};
        int d2_set[5]  = '{0, 0, 1, 3, 11};

        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk(tx_permit, 1'b1, "R1 reset");

        // R3, R4, R10: own-frame gap, both speeds
        for (int s = 0; s < 2; s++) begin
            speed_100 = (s == 0);
            k = speed_100 ? 1 : DIV;
            for (int j = 0; j < 6; j++) begin
                cfg_word = mk_cfg(b2b_set[j], 17, 11);
                send_frame(b2b_set[j] * k,
                    $sformatf("R3 R4 R10 spd100=%0b gap=%0d", speed_100, b2b_set[j]));
            end
        end

        // R5, R4: two-phase deferral after carrier
        for (int s = 0; s < 2; s++) begin
            speed_100 = (s == 0);
            k = speed_100 ? 1 : DIV;
            for (int j = 0; j < 5; j++) begin
                cfg_word = mk_cfg(5, d1_set[j], d2_set[j]);
                carrier_event((d1_set[j] + d2_set[j]) * k,
                    $sformatf("R5 R4 spd100=%0b a=%0d b=%0d", speed_100, d1_set[j], d2_set[j]));
            end
        end

        // R6: carrier inside phase A restarts deferral
        speed_100 = 1'b1;
        cfg_word = mk_cfg(2, 4, 3);
        crs = 1'b1;
        cyc(2);
        crs = 1'b0;
        cyc(2);
        pulse_tick();
        pulse_tick();
        pulse_tick();
        chk(tx_permit, 1'b0, "R6 mid phase A");
        crs = 1'b1;
        cyc(1);
        crs = 1'b0;
        run_gap(7, "R6 restart");

        // R7: carrier inside phase B is ignored
        cfg_word = mk_cfg(2, 4, 5);
        crs = 1'b1;
        cyc(2);
        crs = 1'b0;
        cyc(2);
        for (int i = 0; i < 4; i++) pulse_tick();
        chk(tx_permit, 1'b0, "R7 entered phase B");
        crs = 1'b1;
        cyc(1);
        crs = 1'b0;
        cyc(1);
        for (int i = 1; i <= 5; i++) begin
            pulse_tick();
            chk(tx_permit, i >= 5, "R7 phase B unchanged");
        end

        // R8: full duplex ignores carrier
        full_duplex = 1'b1;
        crs = 1'b1;
        cyc(2);
        chk(tx_permit, 1'b1, "R8 idle with carrier");
        cfg_word = mk_cfg(3, 17, 11);
        send_frame(3, "R8 gap only");
        cyc(3);
        chk(tx_permit, 1'b1, "R8 still open");
        crs = 1'b0;
        full_duplex = 1'b0;
        cyc(2);

        // R9: configuration change mid-gap
        cfg_word = mk_cfg(6, 17, 11);
        tx_req = 1'b1;
        cyc(1);
        tx_req = 1'b0;
        tx_done = 1'b1;
        cyc(1);
        tx_done = 1'b0;
        cyc(4);
        pulse_tick();
        pulse_tick();
        cfg_word = mk_cfg(1, 17, 11);
        chk(tx_permit, 1'b0, "R9 old gap holds");
        for (int i = 3; i <= 6; i++) begin
            pulse_tick();
            chk(tx_permit, i >= 6, "R9 old gap holds");
        end
        send_frame(1, "R9 new gap next frame");

        cfg_word = mk_cfg(2, 3, 2);
        crs = 1'b1;
        cyc(2);
        crs = 1'b0;
        cyc(2);
        pulse_tick();
        cfg_word = mk_cfg(2, 40, 2);
        for (int i = 2; i <= 5; i++) begin
            pulse_tick();
            chk(tx_permit, i >= 5, "R9 phase A value latched");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule